// File: doc/BRIEF.md
# Raster Timing and Cycle Position Unit

This unit keeps the raster position of a video frame that is 341 dots wide and 262 lines tall. The position is counted from the vertical-interrupt point. The raster is driven by a processor clock enable, and every enabled processor cycle moves the dot position forward by three. A processor cycle counter starts at zero on a frame-start pulse. From the running count the unit keeps a dot offset within the line and a line number. It also derives a signed visible-line value and the horizontal blanking, vertical blanking and visible-area flags.

The unit also answers a scheduling question for the rest of the chip. Given a visible line Y and a dot X, it reports the processor cycle at which the raster reaches that spot. The formula is floor(((Y + 21) × 341 + X) / 3). A one-cycle strobe marks each new answer. This lets a scheduler predict when a screen event will happen without waiting for the raster to get there.

Top module: `raster_pos_unit`

## Requirements
- R1: One clock after reset or after a frameStart pulse, cpuCycle, dotPos and linePos are all 0. A frameStart wins over a cpuTick in the same clock.
- R2: A clock with cpuTick high and frameStart low adds 1 to cpuCycle. A clock with neither input high leaves cpuCycle, dotPos and linePos unchanged.
- R3: dotPos always equals (3 × cpuCycle) mod 341 and is never above 340.
- R4: linePos always equals floor(3 × cpuCycle / 341) mod 262. Line 0 is the line of the vertical-interrupt point.
- R5: visLine is the two's-complement value linePos − 21. It is 10 bits wide and negative during the 21 leading blank lines. vblank is high when linePos < 21 or linePos ≥ 261.
- R6: hblank is high exactly when dotPos ≥ 256.
- R7: visible is high exactly when both vblank and hblank are low.
- R8: A clock with targetReq high makes targetValid high for exactly the next clock. In that clock targetCycle equals floor(((targetLine + 21) × 341 + targetDot) / 3). In clocks that follow no request, targetValid is low.
- R9: targetCycle changes only on a request, whatever cpuTick and frameStart do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpuTick | input | 1 | Processor clock enable; one step of 3 dots |
| frameStart | input | 1 | Restarts the cycle count at the vertical-interrupt point |
| targetReq | input | 1 | Requests a cycle computation for the target position |
| targetLine | input | 9 | Target visible line Y |
| targetDot | input | 9 | Target dot X within the line |
| cpuCycle | output | 18 | Processor cycles since the last frame start |
| dotPos | output | 9 | Dot offset within the current line |
| linePos | output | 9 | Line number counted from the vertical-interrupt point |
| visLine | output | 10 | Signed visible line, linePos − 21 |
| visible | output | 1 | Raster is inside the 256 × 240 display area |
| hblank | output | 1 | Dot offset is beyond the displayed width |
| vblank | output | 1 | Line is outside the displayed lines |
| targetCycle | output | 18 | Processor cycle at which the target position is reached |
| targetValid | output | 1 | One-clock strobe for a new targetCycle |

## Verification
The bench runs a whole frame of consecutive ticks and goes past the 262-line wrap. A wrong wrap would show up as a dot offset stuck above 340, or as a line count that drifts from floor(3c/341) at the 2-dot and 1-dot carries that the non-multiple width causes. Tick gaps and a frameStart that coincides with a tick probe the hold and priority rules. A counter that still advanced on such clocks would lose the relation between cycle and position. The target sweep covers every visible line at dots 0, 1, 2, 255, 256 and 340, where a wrong rounding or a missing 21-line offset gives a cycle off by one or by about 2387. Requests made during ticking show whether the raster motion disturbs the held answer.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;   // restart counters at the vertical-interrupt point
    logic advance;    // one processor cycle elapsed
    logic loadTarget; // capture a new target cycle
  } ctlStrobes_t;
endpackage

// File: rtl/raster_ctrl.sv
`timescale 1ns/1ps
module raster_ctrl
  import raster_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpuTick,
  input  logic        frameStart,
  input  logic        targetReq,
  output ctlStrobes_t ctl,
  output logic        targetValid
);
  // frame restart takes priority over a tick in the same clock
  always_comb begin
    ctl.clearAll   = frameStart;
    ctl.advance    = cpuTick & ~frameStart;
    ctl.loadTarget = targetReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) targetValid <= 1'b0;
    else        targetValid <= targetReq;
  end
endmodule

// File: rtl/raster_datapath.sv
`timescale 1ns/1ps
module raster_datapath
  import raster_pkg::*;
#(
  parameter int LINE_DOTS   = 341,
  parameter int FRAME_LINES = 262,
  parameter int SHOW_DOTS   = 256,
  parameter int SHOW_LINES  = 240,
  parameter int LEAD_LINES  = 21,
  parameter int DOT_STEP    = 3,
  parameter int CYC_W       = 18,
  localparam int DOT_W      = $clog2(LINE_DOTS),
  localparam int LINE_W     = $clog2(FRAME_LINES)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctlStrobes_t             ctl,
  input  logic [LINE_W-1:0]       targetLine,
  input  logic [DOT_W-1:0]        targetDot,
  output logic [CYC_W-1:0]        cpuCycle,
  output logic [DOT_W-1:0]        dotPos,
  output logic [LINE_W-1:0]       linePos,
  output logic signed [LINE_W:0]  visLine,
  output logic                    visible,
  output logic                    hblank,
  output logic                    vblank,
  output logic [CYC_W-1:0]        targetCycle
);
  localparam logic [DOT_W:0]    DOT_LIMIT  = (DOT_W+1)'(LINE_DOTS);
  localparam logic [DOT_W:0]    DOT_INC    = (DOT_W+1)'(DOT_STEP);
  localparam logic [DOT_W-1:0]  DOT_SHOWN  = DOT_W'(SHOW_DOTS);
  localparam logic [LINE_W-1:0] LINE_LAST  = LINE_W'(FRAME_LINES - 1);
  localparam logic [LINE_W-1:0] LINE_FIRST = LINE_W'(LEAD_LINES);
  localparam logic [LINE_W-1:0] LINE_END   = LINE_W'(LEAD_LINES + SHOW_LINES);

  logic [CYC_W-1:0]  cycleQ;
  logic [DOT_W-1:0]  dotQ;
  logic [LINE_W-1:0] lineQ;
  logic [CYC_W-1:0]  tgtQ;

  // dot stepping: add the step, fold back once past the line width
  logic [DOT_W:0]    dotSum;
  logic              dotWrap;
  logic [DOT_W-1:0]  dotNext;
  logic [LINE_W-1:0] lineNext;

  always_comb begin
    dotSum   = {1'b0, dotQ} + DOT_INC;
    dotWrap  = (dotSum >= DOT_LIMIT);
    dotNext  = dotWrap ? DOT_W'(dotSum - DOT_LIMIT) : dotSum[DOT_W-1:0];
    if (!dotWrap)                lineNext = lineQ;
    else if (lineQ == LINE_LAST) lineNext = '0;
    else                         lineNext = lineQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycleQ <= '0;
      dotQ   <= '0;
      lineQ  <= '0;
    end else if (ctl.clearAll) begin
      cycleQ <= '0;
      dotQ   <= '0;
      lineQ  <= '0;
    end else if (ctl.advance) begin
      cycleQ <= cycleQ + 1'b1;
      dotQ   <= dotNext;
      lineQ  <= lineNext;
    end
  end

  // target position to processor cycle, rounding down
  logic [CYC_W-1:0] tgtDots;
  always_comb begin
    tgtDots = (CYC_W'(targetLine) + CYC_W'(LEAD_LINES)) * CYC_W'(LINE_DOTS)
              + CYC_W'(targetDot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tgtQ <= '0;
    else if (ctl.loadTarget) tgtQ <= tgtDots / CYC_W'(DOT_STEP);
  end

  // flags
  always_comb begin
    vblank  = (lineQ < LINE_FIRST) || (lineQ >= LINE_END);
    hblank  = (dotQ >= DOT_SHOWN);
    visible = ~vblank & ~hblank;
    visLine = $signed({1'b0, lineQ}) - $signed({1'b0, LINE_FIRST});
  end

  assign cpuCycle    = cycleQ;
  assign dotPos      = dotQ;
  assign linePos     = lineQ;
  assign targetCycle = tgtQ;
endmodule

// File: rtl/raster_pos_unit.sv
`timescale 1ns/1ps
module raster_pos_unit
  import raster_pkg::*;
#(
  parameter int LINE_DOTS   = 341,
  parameter int FRAME_LINES = 262,
  parameter int SHOW_DOTS   = 256,
  parameter int SHOW_LINES  = 240,
  parameter int LEAD_LINES  = 21,
  parameter int DOT_STEP    = 3,
  parameter int CYC_W       = 18,
  localparam int DOT_W      = $clog2(LINE_DOTS),
  localparam int LINE_W     = $clog2(FRAME_LINES)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpuTick,
  input  logic                   frameStart,
  input  logic                   targetReq,
  input  logic [LINE_W-1:0]      targetLine,
  input  logic [DOT_W-1:0]       targetDot,
  output logic [CYC_W-1:0]       cpuCycle,
  output logic [DOT_W-1:0]       dotPos,
  output logic [LINE_W-1:0]      linePos,
  output logic signed [LINE_W:0] visLine,
  output logic                   visible,
  output logic                   hblank,
  output logic                   vblank,
  output logic [CYC_W-1:0]       targetCycle,
  output logic                   targetValid
);
  ctlStrobes_t ctl;

  raster_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpuTick(cpuTick), .frameStart(frameStart),
    .targetReq(targetReq), .ctl(ctl), .targetValid(targetValid)
  );

  raster_datapath #(
    .LINE_DOTS(LINE_DOTS), .FRAME_LINES(FRAME_LINES), .SHOW_DOTS(SHOW_DOTS),
    .SHOW_LINES(SHOW_LINES), .LEAD_LINES(LEAD_LINES), .DOT_STEP(DOT_STEP),
    .CYC_W(CYC_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .targetLine(targetLine), .targetDot(targetDot),
    .cpuCycle(cpuCycle), .dotPos(dotPos), .linePos(linePos),
    .visLine(visLine), .visible(visible), .hblank(hblank), .vblank(vblank),
    .targetCycle(targetCycle)
  );
endmodule

// File: rtl/raster_pos_checker.sv
`timescale 1ns/1ps
module raster_pos_checker #(
  parameter int LINE_DOTS   = 341,
  parameter int FRAME_LINES = 262,
  parameter int DOT_STEP    = 3,
  parameter int CYC_W       = 18,
  localparam int DOT_W      = $clog2(LINE_DOTS),
  localparam int LINE_W     = $clog2(FRAME_LINES)
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cpuTick,
  input logic              frameStart,
  input logic              targetReq,
  input logic [CYC_W-1:0]  cpuCycle,
  input logic [DOT_W-1:0]  dotPos,
  input logic [LINE_W-1:0] linePos,
  input logic              visible,
  input logic              hblank,
  input logic              vblank,
  input logic [CYC_W-1:0]  targetCycle,
  input logic              targetValid
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> (cpuCycle == '0) && (dotPos == '0) && (linePos == '0));

  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpuTick && !frameStart |=> cpuCycle == $past(cpuCycle) + 1'b1);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpuTick && !frameStart |=> $stable(cpuCycle) && $stable(dotPos) && $stable(linePos));

  assert_dot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpuTick && !frameStart |=>
      int'(dotPos) == (int'($past(dotPos)) + DOT_STEP) % LINE_DOTS);

  assert_dot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dotPos) < LINE_DOTS);

  assert_line_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpuTick && !frameStart && (int'(dotPos) + DOT_STEP >= LINE_DOTS) |=>
      int'(linePos) == (int'($past(linePos)) + 1) % FRAME_LINES);

  assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    visible |-> !hblank && !vblank);

  assert_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    targetReq |=> targetValid);

  assert_novalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !targetReq |=> !targetValid);

  assert_tgt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !targetReq |=> $stable(targetCycle));
endmodule

bind raster_pos_unit raster_pos_checker #(
  .LINE_DOTS(LINE_DOTS), .FRAME_LINES(FRAME_LINES),
  .DOT_STEP(DOT_STEP), .CYC_W(CYC_W)
) u_chk (.*);

// File: tb/raster_pos_unit_bench.sv
`timescale 1ns/1ps
module raster_pos_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpuTick = 1'b0, frameStart = 1'b0, targetReq = 1'b0;
  logic [8:0] targetLine = '0, targetDot = '0;
  logic [17:0] cpuCycle, targetCycle;
  logic [8:0] dotPos, linePos;
  logic signed [9:0] visLine;
  logic visible, hblank, vblank, targetValid;

  always #4 clk = ~clk;

  raster_pos_unit u_raster_pos_unit (
    .clk(clk), .rst_n(rst_n), .cpuTick(cpuTick), .frameStart(frameStart),
    .targetReq(targetReq), .targetLine(targetLine), .targetDot(targetDot),
    .cpuCycle(cpuCycle), .dotPos(dotPos), .linePos(linePos), .visLine(visLine),
    .visible(visible), .hblank(hblank), .vblank(vblank),
    .targetCycle(targetCycle), .targetValid(targetValid)
  );

  int nChecks = 0, nFails = 0;
  int expCyc = 0, expTgt = 0;
  bit expValid = 0, tgtKnown = 0, done = 0;

  task automatic cmp(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, expCyc);
    end
  endtask

  task automatic checkAll();
    int d, l;
    bit vb, hb;
    d  = (3 * expCyc) % 341;
    l  = ((3 * expCyc) / 341) % 262;
    vb = (l < 21) || (l >= 261);
    hb = (d >= 256);
    cmp("R2", "cpuCycle", int'(cpuCycle), expCyc);
    cmp("R3", "dotPos", int'(dotPos), d);
    cmp("R4", "linePos", int'(linePos), l);
    cmp("R5", "vblank", int'(vblank), int'(vb));
    cmp("R5", "visLine", int'(visLine), l - 21);
    cmp("R6", "hblank", int'(hblank), int'(hb));
    cmp("R7", "visible", int'(visible), int'(!vb && !hb));
    cmp("R8", "targetValid", int'(targetValid), int'(expValid));
    if (tgtKnown) cmp(expValid ? "R8" : "R9", "targetCycle", int'(targetCycle), expTgt);
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic step(input bit tk, input bit fs, input bit rq, input int y, input int x);
    cpuTick = tk; frameStart = fs; targetReq = rq;
    targetLine = 9'(y); targetDot = 9'(x);
    @(posedge clk);
    if (fs) expCyc = 0;
    else if (tk) expCyc = expCyc + 1;
    expValid = rq;
    if (rq) begin
      expTgt = ((y + 21) * 341 + x) / 3;
      tgtKnown = 1;
    end
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    int xs[6] = '{0, 1, 2, 255, 256, 340};
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "cpuCycle after reset", int'(cpuCycle), 0);
    cmp("R1", "dotPos after reset", int'(dotPos), 0);
    cmp("R1", "linePos after reset", int'(linePos), 0);
    cmp("R1", "targetValid after reset", int'(targetValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 1, 0, 0, 0);
    // full frame plus wrap, with requests sprinkled in (R9 independence)
    for (int k = 0; k < 29781 + 400; k++) begin
      if (k % 97 == 5) step(1, 0, 1, k % 240, k % 341);
      else             step(1, 0, 0, 0, 0);
    end
    // R2: no tick holds
    for (int k = 0; k < 50; k++) step(0, 0, 0, 0, 0);
    // irregular tick pattern
    for (int k = 0; k < 1500; k++) step(k % 3 != 0, 0, 0, 0, 0);
    // R1: frameStart with tick wins
    step(1, 1, 0, 0, 0);
    cmp("R1", "cpuCycle after frameStart+tick", int'(cpuCycle), 0);
    cmp("R1", "dotPos after frameStart+tick", int'(dotPos), 0);
    for (int k = 0; k < 700; k++) step(1, 0, 0, 0, 0);
    // R9: frameStart leaves target alone
    step(0, 1, 0, 0, 0);
    // R8: target sweep
    for (int y = 0; y < 240; y++)
      foreach (xs[i]) step(0, 0, 1, y, xs[i]);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule